// File: doc/BRIEF.md
# Multiport RAM with Per-Bit Write Enables

This block is a register-based memory of `2**ABITS` words, each `WIDTH` bits wide, with any number of write ports and read ports. All per-port signals travel on flat vectors: port `i` of a signal group sits at slice `[i*WIDTH +: WIDTH]` for data and enables, and at `[i*ABITS +: ABITS]` for addresses. Every write port carries one enable bit per data bit, so a port can change any subset of a word's bits and leave the rest as they were.

Read ports are synchronous. Each one registers a word when its read enable is high and holds its output when the enable is low. A per-port parameter bit decides what a read returns when it collides with a write to the same address in the same cycle. A transparent port returns the word as it will be after the write: the written bits where the enable is high, the stored bits elsewhere. A non-transparent port returns the word as it was before the write.

When more than one write port targets the same bit in one cycle, the highest-numbered port wins. All ports share one clock, and an active-low reset clears the array and the read outputs.

Top module: `mpram_top`

## Requirements
- R1: While reset is low and in the first cycle after it, every read output is zero, and every stored word reads back as zero until it is written.
- R2: A write changes exactly the data bits whose enable bit is 1. Bits whose enable bit is 0 keep their stored value.
- R3: When several write ports write the same bit of the same address in one cycle, the stored result is the value from the highest-numbered of those ports.
- R4: A read with its enable high at a clock edge shows the selected word on that port's output slice `[i*WIDTH +: WIDTH]` just after that edge.
- R5: A read port whose bit in `RD_TRANSP` is 0 returns the pre-write content when a write to the same address happens in the same cycle.
- R6: A read port whose bit in `RD_TRANSP` is 1 returns, on such a collision, the post-write word. That word has written bits where an enable is 1 and stored bits elsewhere.
- R7: A read port whose enable is low keeps its output unchanged, even while writes modify the word it last read.
- R8: Write port `i` takes its enable and data from slice `[i*WIDTH +: WIDTH]` and its address from `[i*ABITS +: ABITS]`. Addresses are unsigned.
- R9: Address `2**ABITS-1` is written and read like any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | WR_PORTS*WIDTH | Per-bit write enables, packed per port |
| wr_addr | input | WR_PORTS*ABITS | Write addresses, packed per port |
| wr_data | input | WR_PORTS*WIDTH | Write data, packed per port |
| rd_en | input | RD_PORTS | Read enable, one bit per read port |
| rd_addr | input | RD_PORTS*ABITS | Read addresses, packed per port |
| rd_data | output | RD_PORTS*WIDTH | Registered read data, packed per port |

## Verification
Directed writes with full and partial enable masks separate true per-bit masking from word-wide writes. Two ports hitting one address with overlapping masks expose which port takes priority. Same-cycle read-write collisions are issued to a transparent port and an old-data port at the same time, so a swapped mode or a missing merge shows up as a mismatch between the two ports. Long random traffic is confined mostly to four addresses so that collisions are frequent, and random read-enable gaps check that idle ports hold their output.

// File: rtl/mpram_pkg.sv
package mpram_pkg;

    // Collision behaviour of a read port
    typedef enum logic {
        RD_OLD = 1'b0,   // pre-write content
        RD_NEW = 1'b1    // post-write (merged) content
    } rd_mode_e;

endpackage

// File: rtl/mpram_wr_merge.sv
// Combinational next-state of the array: applies every write port in
// ascending order, so a higher port overrides a lower one bit by bit.
module mpram_wr_merge #(
    parameter int WIDTH    = 8,
    parameter int ABITS    = 4,
    parameter int WR_PORTS = 2,
    localparam int DEPTH   = 1 << ABITS
) (
    input  logic [WR_PORTS*WIDTH-1:0]       wr_en,
    input  logic [WR_PORTS*ABITS-1:0]       wr_addr,
    input  logic [WR_PORTS*WIDTH-1:0]       wr_data,
    input  logic [DEPTH-1:0][WIDTH-1:0]     store_q,
    output logic [DEPTH-1:0][WIDTH-1:0]     store_d
);

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_comb begin
            logic [WIDTH-1:0] word_d;
            word_d = store_q[w];
            for (int p = 0; p < WR_PORTS; p++) begin
                if (wr_addr[p*ABITS +: ABITS] == ABITS'(w)) begin
                    word_d = (word_d & ~wr_en[p*WIDTH +: WIDTH])
                           | (wr_data[p*WIDTH +: WIDTH] & wr_en[p*WIDTH +: WIDTH]);
                end
            end
            store_d[w] = word_d;
        end
    end

endmodule

// File: rtl/mpram_rd_port.sv
// One synchronous read port; MODE picks old or merged data on collision.
module mpram_rd_port
    import mpram_pkg::*;
#(
    parameter int       WIDTH = 8,
    parameter int       ABITS = 4,
    parameter rd_mode_e MODE  = RD_OLD,
    localparam int      DEPTH = 1 << ABITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [ABITS-1:0]            rd_addr,
    input  logic [DEPTH-1:0][WIDTH-1:0] store_q,
    input  logic [DEPTH-1:0][WIDTH-1:0] store_d,
    output logic [WIDTH-1:0]            rd_data
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [DEPTH-1:0][WIDTH-1:0] src;

    always_comb begin
        src  = (MODE == RD_NEW) ? store_d : store_q;
        st_d = st_q;
        if (rd_en) begin
            st_d.data = src[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.data;

    // R7: idle port keeps its output
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/mpram_top.sv
module mpram_top
    import mpram_pkg::*;
#(
    parameter int                  WIDTH     = 8,
    parameter int                  ABITS     = 4,
    parameter int                  WR_PORTS  = 2,
    parameter int                  RD_PORTS  = 3,
    parameter logic [RD_PORTS-1:0] RD_TRANSP = 3'b010,
    localparam int                 DEPTH     = 1 << ABITS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WR_PORTS*WIDTH-1:0] wr_en,
    input  logic [WR_PORTS*ABITS-1:0] wr_addr,
    input  logic [WR_PORTS*WIDTH-1:0] wr_data,
    input  logic [RD_PORTS-1:0]       rd_en,
    input  logic [RD_PORTS*ABITS-1:0] rd_addr,
    output logic [RD_PORTS*WIDTH-1:0] rd_data
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
    } arr_state_t;

    arr_state_t st_d, st_q;
    logic [DEPTH-1:0][WIDTH-1:0] merged;

    mpram_wr_merge #(
        .WIDTH    (WIDTH),
        .ABITS    (ABITS),
        .WR_PORTS (WR_PORTS)
    ) u_merge (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .store_q (st_q.mem),
        .store_d (merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.mem = merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
        mpram_rd_port #(
            .WIDTH (WIDTH),
            .ABITS (ABITS),
            .MODE  (rd_mode_e'(RD_TRANSP[r]))
        ) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (rd_en[r]),
            .rd_addr (rd_addr[r*ABITS +: ABITS]),
            .store_q (st_q.mem),
            .store_d (merged),
            .rd_data (rd_data[r*WIDTH +: WIDTH])
        );

        // does any write port touch this read address this cycle
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int p = 0; p < WR_PORTS; p++) begin
                if (wr_addr[p*ABITS +: ABITS] == rd_addr[r*ABITS +: ABITS]
                    && wr_en[p*WIDTH +: WIDTH] != '0) begin
                    hit = 1'b1;
                end
            end
        end

        if (RD_TRANSP[r]) begin : g_new
            // R6: transparent read equals the word as stored after the edge
            a_r6_new_data: assert property (@(posedge clk) disable iff (!rst_n)
                rd_en[r] |=> rd_data[r*WIDTH +: WIDTH]
                    == st_q.mem[$past(rd_addr[r*ABITS +: ABITS])]);
        end else begin : g_old
            // R5/R4: without a colliding write, read equals stored word
            a_r5_old_data: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en[r] && !hit) |=> rd_data[r*WIDTH +: WIDTH]
                    == st_q.mem[$past(rd_addr[r*ABITS +: ABITS])]);
        end
    end

    localparam int HI = WR_PORTS - 1;

    // R2: no enabled bit means the array does not change
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> $stable(st_q));

    // R3: a full-word write on the top port always lands
    a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[HI*WIDTH +: WIDTH] == '1) |=>
            st_q.mem[$past(wr_addr[HI*ABITS +: ABITS])]
                == $past(wr_data[HI*WIDTH +: WIDTH]));

    // R1: reset clears the read outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));

endmodule

// File: tb/sim_mpram_top.sv
`timescale 1ns/1ps
module sim_mpram_top;

    localparam int WIDTH = 8;
    localparam int ABITS = 4;
    localparam int WP    = 2;
    localparam int RP    = 3;
    localparam logic [RP-1:0] TRANSP = 3'b010;
    localparam int DEPTH = 1 << ABITS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WP*WIDTH-1:0] wr_en = '0;
    logic [WP*ABITS-1:0] wr_addr = '0;
    logic [WP*WIDTH-1:0] wr_data = '0;
    logic [RP-1:0]       rd_en = '0;
    logic [RP*ABITS-1:0] rd_addr = '0;
    logic [RP*WIDTH-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [WIDTH-1:0] m_mem [DEPTH];
    logic [WIDTH-1:0] m_out [RP];

    always #10 clk = ~clk;   // 50 MHz

    mpram_top #(
        .WIDTH(WIDTH), .ABITS(ABITS), .WR_PORTS(WP), .RD_PORTS(RP), .RD_TRANSP(TRANSP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [WIDTH-1:0] apply_bits(input logic [WIDTH-1:0] old,
            input logic [WIDTH-1:0] d, input logic [WIDTH-1:0] en);
        return (old & ~en) | (d & en);
    endfunction

    task automatic check(input string tag, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_wr(input int p, input int a, input logic [WIDTH-1:0] d,
                          input logic [WIDTH-1:0] en);
        wr_addr[p*ABITS +: ABITS] = ABITS'(a);
        wr_data[p*WIDTH +: WIDTH] = d;
        wr_en[p*WIDTH +: WIDTH]   = en;
    endtask

    task automatic set_rd(input int r, input int a, input logic e);
        rd_addr[r*ABITS +: ABITS] = ABITS'(a);
        rd_en[r] = e;
    endtask

    task automatic clear_in();
        wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = '0; rd_addr = '0;
    endtask

    // one clock: predict, step, compare; called just after a falling edge
    task automatic cycle(input string tag);
        logic [WIDTH-1:0] nxt [DEPTH];
        for (int w = 0; w < DEPTH; w++) nxt[w] = m_mem[w];
        for (int p = 0; p < WP; p++) begin
            int a = int'(wr_addr[p*ABITS +: ABITS]);
            nxt[a] = apply_bits(nxt[a], wr_data[p*WIDTH +: WIDTH], wr_en[p*WIDTH +: WIDTH]);
        end
        for (int r = 0; r < RP; r++) begin
            int a = int'(rd_addr[r*ABITS +: ABITS]);
            if (rd_en[r]) m_out[r] = TRANSP[r] ? nxt[a] : m_mem[a];
        end
        @(posedge clk);
        for (int w = 0; w < DEPTH; w++) m_mem[w] = nxt[w];
        @(negedge clk);
        for (int r = 0; r < RP; r++) begin
            string t;
            t = (tag != "") ? tag : (TRANSP[r] ? "R6" : "R5");
            check($sformatf("%s port%0d", t, r), rd_data[r*WIDTH +: WIDTH], m_out[r]);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int w = 0; w < DEPTH; w++) m_mem[w] = '0;
        for (int r = 0; r < RP; r++) m_out[r] = '0;

        // R1: outputs zero under reset
        repeat (3) @(negedge clk);
        for (int r = 0; r < RP; r++) check("R1 reset out", rd_data[r*WIDTH +: WIDTH], '0);
        rst_n = 1'b1;

        // R1: every word reads zero after reset, through port 0
        for (int a = 0; a < DEPTH; a++) begin
            clear_in(); set_rd(0, a, 1'b1);
            cycle("R1");
        end

        // R6/R5: collision, full mask, port1 transparent, port0/2 old
        clear_in();
        set_wr(0, 5, 8'hA5, 8'hFF);
        set_rd(0, 5, 1'b1); set_rd(1, 5, 1'b1); set_rd(2, 5, 1'b1);
        cycle("");
        check("R6 directed new", rd_data[1*WIDTH +: WIDTH], 8'hA5);
        check("R5 directed old", rd_data[0*WIDTH +: WIDTH], 8'h00);

        // R2/R6/R8: partial mask on port 1 merges with stored bits
        clear_in();
        set_wr(1, 5, 8'h0F, 8'h3C);
        set_rd(1, 5, 1'b1);
        cycle("R2");
        check("R6 partial merge", rd_data[1*WIDTH +: WIDTH], 8'h8D);

        // R3: overlapping ports on one address, port 1 wins high nibble
        clear_in();
        set_wr(0, 9, 8'hFF, 8'hFF);
        set_wr(1, 9, 8'h00, 8'hF0);
        cycle("R3");
        clear_in(); set_rd(0, 9, 1'b1);
        cycle("R3");
        check("R3 priority", rd_data[0 +: WIDTH], 8'h0F);

        // R9: top address
        clear_in();
        set_wr(0, DEPTH-1, 8'h3C, 8'hFF);
        cycle("R9");
        clear_in(); set_rd(2, DEPTH-1, 1'b1);
        cycle("R9");
        check("R9 top address", rd_data[2*WIDTH +: WIDTH], 8'h3C);

        // R7: idle port holds across a write to the word it read
        clear_in();
        set_wr(1, DEPTH-1, 8'hC3, 8'hFF);
        cycle("R7");
        check("R7 hold", rd_data[2*WIDTH +: WIDTH], 8'h3C);

        // R4/R5/R6/R2/R3: random traffic on a narrow address window
        for (int i = 0; i < 3000; i++) begin
            clear_in();
            for (int p = 0; p < WP; p++) begin
                int a;
                a = ($urandom % 8 == 0) ? int'($urandom % DEPTH) : int'($urandom % 4);
                set_wr(p, a, WIDTH'($urandom),
                       ($urandom % 4 == 0) ? '0 : WIDTH'($urandom));
            end
            for (int r = 0; r < RP; r++) begin
                set_rd(r, int'($urandom % 4), ($urandom % 4 != 0));
            end
            cycle("");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule